// File: doc/BRIEF.md
# Eight-Entry Label Match Filter

This block keeps eight 8-bit label values and decides, for every word arriving at a serial receiver, whether that word may be reported to the host. The host fills the table and reads it back through the shared 8-bit data port. Each direction is a run of eight data accesses that a control write starts. A control write that raises the load bit starts a load run. A control write that raises the read bit starts a read-back run. Each following data access then moves to the next table entry.

The receiver hands over the first byte of each word (its label) as soon as the eighth bit has been sampled. In the same cycle the block compares that byte against all eight entries and drives an accept signal. The receiver uses accept to gate its ready and first-character indications. A word whose label matches no entry is dropped without any error being raised. Filtering only takes effect while the hardware feature-select input is high and the load bit of the control byte is set.

Top module: `label_match_filter`

## Requirements
- R1: After reset all eight entries hold 0x00, no load or read run is armed, and a data read returns 0x00 with `lbl_rd_sel_o` low.
- R2: A control write whose bit 7 (load bit) is 1, when the previously written value of that bit was 0, arms a load run. The next eight data writes store their bytes into entries 1 to 8 in that order.
- R3: A control write whose bit 1 (read bit) is 1, when the previously written value of that bit was 0, arms a read run. The next eight data reads return entries 1 to 8 in order, with `lbl_rd_sel_o` high during each of them. The ninth read has `lbl_rd_sel_o` low and returns 0x00.
- R4: Writing the read bit as 1 again while it is already 1 does not arm a new read run. Only a write of 0 followed by a write of 1 arms one.
- R5: Writing the load bit as 1 while it is already 1 does not arm a load run. Data writes made while no load run is active leave every entry unchanged.
- R6: A new rising edge of the load bit in the middle of a load run restarts that run at entry 1.
- R7: While `feature_sel_i` is low, or the most recently written load bit is 0, `accept_o` is 1 for every label.
- R8: While filtering is on, `accept_o` is 1 in the cycle where `rx_label_stb_i` is high exactly when `rx_label_i` equals at least one entry. Duplicate entries are allowed.
- R9: While filtering is on, `accept_o` keeps the verdict of the most recent label strobe until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| feature_sel_i | input | 1 | Hardware feature select; filtering is possible only when high |
| ctl_wr_i | input | 1 | One-cycle control-register write strobe |
| ctl_wdata_i | input | 8 | Control byte (bit 7 load/filter enable, bit 1 read-back) |
| dat_wr_i | input | 1 | One-cycle data-port write strobe |
| dat_wdata_i | input | 8 | Data-port write byte |
| dat_rd_i | input | 1 | One-cycle data-port read strobe |
| dat_rdata_o | output | 8 | Entry returned during a read run, 0x00 otherwise |
| lbl_rd_sel_o | output | 1 | High while a data read is served from the table |
| rx_label_stb_i | input | 1 | Strobe: first eight bits of a word are complete |
| rx_label_i | input | 8 | Received label byte |
| accept_o | output | 1 | Word may be reported to the host |

## Verification
The hardest situation to reach from the ports is a load run that is cut short by a second rising edge of the load bit. Detecting that the count restarted rather than continued needs a full read-back run afterwards. The stimulus writes three bytes, drops and raises the load bit, and writes eight new bytes. It then reads the table back and compares every entry. A counter that continued would have stored the last bytes past the end of the run, where they would be lost. Matching is exercised with labels drawn at random, half taken from the table and half arbitrary, and a duplicate entry is kept in the table.

// File: rtl/lblf_pkg.sv
package lblf_pkg;
  localparam int LBL_W    = 8;
  localparam int N_LBL    = 8;
  localparam int LOAD_POS = 7;
  localparam int READ_POS = 1;
endpackage

// File: rtl/lblf_ctl_edge.sv
module lblf_ctl_edge #(
  parameter int W        = 8,
  parameter int LOAD_POS = 7,
  parameter int READ_POS = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_wr_i,
  input  logic [W-1:0] ctl_wdata_i,
  input  logic         feature_sel_i,
  output logic         load_arm_o,
  output logic         read_arm_o,
  output logic         filt_en_o
);
  logic load_q, load_d;
  logic read_q, read_d;
  logic upd_en;

  assign upd_en = ctl_wr_i;

  always_comb begin
    load_d = load_q;
    read_d = read_q;
    if (upd_en) begin
      load_d = ctl_wdata_i[LOAD_POS];
      read_d = ctl_wdata_i[READ_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      read_q <= 1'b0;
    end else if (upd_en) begin
      load_q <= load_d;
      read_q <= read_d;
    end
  end

  assign load_arm_o = upd_en & ctl_wdata_i[LOAD_POS] & ~load_q;
  assign read_arm_o = upd_en & ctl_wdata_i[READ_POS] & ~read_q;
  assign filt_en_o  = load_q & feature_sel_i;

  // R4
  read_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_q) |-> $past(read_arm_o));
endmodule

// File: rtl/lblf_seq.sv
module lblf_seq #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          step_i,
  output logic          active_o,
  output logic [IW-1:0] idx_o
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic          act_q, act_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    if (arm_i) begin
      act_d = 1'b1;
      idx_d = '0;
    end else if (step_i && act_q) begin
      if (idx_q == LAST) begin
        act_d = 1'b0;
        idx_d = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
    end
  end

  assign active_o = act_q;
  assign idx_o    = idx_q;

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (idx_q <= LAST));
  // R6
  arm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (act_q && idx_q == '0));
  // R3
  run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && step_i && !arm_i && idx_q == LAST) |=> !act_q);
endmodule

// File: rtl/lblf_store.sv
module lblf_store #(
  parameter int W = 8,
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_data_o,
  input  logic [W-1:0]  cmp_i,
  output logic          hit_o
);
  logic [W-1:0] lbl_q [N];
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic         ent_en;
    logic [W-1:0] ent_d;
    assign ent_en = wr_en_i && (wr_idx_i == IW'(g));
    assign ent_d  = ent_en ? wr_data_i : lbl_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lbl_q[g] <= '0;
      else if (ent_en) lbl_q[g] <= ent_d;
    end
    assign match[g] = (lbl_q[g] == cmp_i);
  end

  assign hit_o     = |match;
  assign rd_data_o = lbl_q[rd_idx_i];

  // R2
  entry_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (lbl_q[$past(wr_idx_i)] == $past(wr_data_i)));
endmodule

// File: rtl/label_match_filter.sv
module label_match_filter
  import lblf_pkg::*;
#(
  parameter int W = LBL_W,
  parameter int N = N_LBL,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         feature_sel_i,
  input  logic         ctl_wr_i,
  input  logic [7:0]   ctl_wdata_i,
  input  logic         dat_wr_i,
  input  logic [W-1:0] dat_wdata_i,
  input  logic         dat_rd_i,
  output logic [W-1:0] dat_rdata_o,
  output logic         lbl_rd_sel_o,
  input  logic         rx_label_stb_i,
  input  logic [W-1:0] rx_label_i,
  output logic         accept_o
);
  logic          ld_arm, rd_arm, filt_en;
  logic          ld_act, rd_act;
  logic [IW-1:0] ld_idx, rd_idx;
  logic [W-1:0]  rd_data;
  logic          hit, hit_q, hit_d;
  logic          st_wr;

  lblf_ctl_edge #(.W(8), .LOAD_POS(LOAD_POS), .READ_POS(READ_POS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
    .feature_sel_i(feature_sel_i), .load_arm_o(ld_arm), .read_arm_o(rd_arm),
    .filt_en_o(filt_en));

  lblf_seq #(.N(N)) u_ld_seq (
    .clk(clk), .rst_n(rst_n), .arm_i(ld_arm), .step_i(dat_wr_i),
    .active_o(ld_act), .idx_o(ld_idx));

  lblf_seq #(.N(N)) u_rd_seq (
    .clk(clk), .rst_n(rst_n), .arm_i(rd_arm), .step_i(dat_rd_i),
    .active_o(rd_act), .idx_o(rd_idx));

  assign st_wr = dat_wr_i & ld_act & ~ld_arm;

  lblf_store #(.W(W), .N(N)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en_i(st_wr), .wr_idx_i(ld_idx),
    .wr_data_i(dat_wdata_i), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .cmp_i(rx_label_i), .hit_o(hit));

  always_comb begin
    hit_d = hit_q;
    if (rx_label_stb_i) hit_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hit_q <= 1'b0;
    else if (rx_label_stb_i) hit_q <= hit_d;
  end

  assign accept_o     = ~filt_en | (rx_label_stb_i ? hit : hit_q);
  assign lbl_rd_sel_o = rd_act;
  assign dat_rdata_o  = rd_act ? rd_data : '0;

  // R9
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_label_stb_i && filt_en && $past(filt_en) && $past(!rx_label_stb_i))
      |-> $stable(accept_o));
  // R7
  pass_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!feature_sel_i) |-> accept_o);
endmodule

// File: tb/tb_label_match_filter.sv
module tb_label_match_filter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       feature_sel_i, ctl_wr_i, dat_wr_i, dat_rd_i, rx_label_stb_i;
  logic [7:0] ctl_wdata_i, dat_wdata_i, rx_label_i;
  logic [7:0] dat_rdata_o;
  logic       lbl_rd_sel_o, accept_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mdl [8];

  always #5 clk = ~clk;

  label_match_filter dut (
    .clk(clk), .rst_n(rst_n), .feature_sel_i(feature_sel_i),
    .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
    .dat_wr_i(dat_wr_i), .dat_wdata_i(dat_wdata_i),
    .dat_rd_i(dat_rd_i), .dat_rdata_o(dat_rdata_o), .lbl_rd_sel_o(lbl_rd_sel_o),
    .rx_label_stb_i(rx_label_stb_i), .rx_label_i(rx_label_i), .accept_o(accept_o));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit ref_hit(input logic [7:0] l);
    for (int i = 0; i < 8; i++) if (mdl[i] == l) return 1'b1;
    return 1'b0;
  endfunction

  task automatic ctl_write(input logic [7:0] b);
    @(negedge clk); ctl_wr_i = 1'b1; ctl_wdata_i = b;
    @(posedge clk); #1 ctl_wr_i = 1'b0;
  endtask

  task automatic dat_write(input logic [7:0] b);
    @(negedge clk); dat_wr_i = 1'b1; dat_wdata_i = b;
    @(posedge clk); #1 dat_wr_i = 1'b0;
  endtask

  task automatic dat_read(input string req, input bit exp_sel, input logic [7:0] exp_d);
    @(negedge clk); dat_rd_i = 1'b1; #2;
    check(req, lbl_rd_sel_o, exp_sel);
    check(req, dat_rdata_o, exp_d);
    @(posedge clk); #1 dat_rd_i = 1'b0;
  endtask

  task automatic read_all(input string req);
    ctl_write(8'h80);
    ctl_write(8'h82);
    for (int i = 0; i < 8; i++) dat_read(req, 1'b1, mdl[i]);
    dat_read(req, 1'b0, 8'h00);
  endtask

  task automatic send_label(input string req, input logic [7:0] l, input bit exp_acc);
    @(negedge clk); rx_label_stb_i = 1'b1; rx_label_i = l; #2;
    check(req, accept_o, exp_acc);
    @(posedge clk); #1 rx_label_stb_i = 1'b0; rx_label_i = $urandom;
    @(negedge clk); #2 check("R9", accept_o, exp_acc);
    @(negedge clk); #2 check("R9", accept_o, exp_acc);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    rst_n = 1'b0; feature_sel_i = 1'b0; ctl_wr_i = 1'b0; dat_wr_i = 1'b0;
    dat_rd_i = 1'b0; rx_label_stb_i = 1'b0;
    ctl_wdata_i = '0; dat_wdata_i = '0; rx_label_i = '0;
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    dat_read("R1", 1'b0, 8'h00);
    ctl_write(8'h02);
    for (int i = 0; i < 8; i++) dat_read("R1", 1'b1, 8'h00);
    ctl_write(8'h00);

    // R2 / R3: load eight entries with a duplicate, read back
    ctl_write(8'h80);
    for (int i = 0; i < 8; i++) begin
      mdl[i] = (i == 5) ? mdl[2] : 8'($urandom);
      dat_write(mdl[i]);
    end
    ctl_write(8'h82);
    for (int i = 0; i < 8; i++) dat_read("R3", 1'b1, mdl[i]);
    dat_read("R3", 1'b0, 8'h00);

    // R4: read bit already 1, no re-arm
    ctl_write(8'h82);
    dat_read("R4", 1'b0, 8'h00);

    // R5: load bit already 1 and idle writes ignored
    ctl_write(8'h80);
    dat_write(8'hA5);
    dat_write(8'h5A);
    read_all("R5");

    // R6: second rising edge mid-run restarts at entry 1
    ctl_write(8'h00);
    ctl_write(8'h80);
    for (int i = 0; i < 3; i++) dat_write(8'($urandom));
    ctl_write(8'h00);
    ctl_write(8'h80);
    for (int i = 0; i < 8; i++) begin
      mdl[i] = 8'($urandom);
      dat_write(mdl[i]);
    end
    read_all("R6");

    // R8: filtering on, random labels
    feature_sel_i = 1'b1;
    ctl_write(8'h80);
    for (int k = 0; k < 40; k++) begin
      logic [7:0] l;
      l = (k % 2 == 0) ? mdl[$urandom_range(7)] : 8'($urandom);
      send_label("R8", l, ref_hit(l));
    end
    // directed: a sure miss then a hit
    begin
      logic [7:0] miss;
      miss = mdl[0];
      while (ref_hit(miss)) miss = miss + 8'd1;
      send_label("R8", miss, 1'b0);
      send_label("R8", mdl[7], 1'b1);
      send_label("R8", miss, 1'b0);

      // R7: feature select low passes everything
      feature_sel_i = 1'b0;
      send_label("R7", miss, 1'b1);
      // R7: load bit 0 passes everything
      feature_sel_i = 1'b1;
      ctl_write(8'h00);
      send_label("R7", miss, 1'b1);
    end

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule